// File: doc/BRIEF.md
# Timer Compare Output Unit

The unit holds a 16-bit compare value and checks it on every clock against one of two free-running timer counts. A select bit picks the timer. When the two values first become equal, a 4-bit mode code decides the action. The output latch can be driven high, driven low or inverted. The unit can instead raise only its interrupt flag, or it can issue a special event that clears the selected timer and, if the converter is enabled, starts an analog-to-digital conversion.

Software loads the compare value, the mode code and the timer select through three simple write strobes. The timers and the converter sit outside the unit and only exchange counts and one-cycle pulses with it. The compare latch reaches the pin through a tristate enable. That enable follows a direction input, which is registered by one clock.

Top module: `cmp_out_unit`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `pin_o`, `pin_oe`, `irq_flag`, `tmr_a_rst`, `tmr_b_rst` and `adc_start` are all 0. The compare value, the mode and the select are all 0.
- R2: The compare value is matched against `timer_a` when the select (written with `tsel_wr`/`tsel_wdata`) is 0 and against `timer_b` when it is 1. Equality on the other timer causes no action.
- R3: A match is the first clock edge at which the compare value equals the selected timer. After that edge, mode 4'b1000 leaves `pin_o` at 1, mode 4'b1001 leaves it at 0 and mode 4'b0010 inverts it.
- R4: Equality that lasts for several cycles counts as one match. It produces no further inversion, flag setting or pulse until equality is lost and found again.
- R5: A match in any of the modes 4'b1000, 4'b1001, 4'b0010, 4'b1010 or 4'b1011 sets `irq_flag` at the same edge as the pin action. The flag stays set until a `flag_clr` strobe. When a clear and a match arrive on the same edge, the flag is left set.
- R6: In mode 4'b1010, a match sets `irq_flag` and leaves `pin_o` unchanged.
- R7: In mode 4'b1011, a match sets `irq_flag`, leaves `pin_o` unchanged and raises the reset pulse of the selected timer only: `tmr_a_rst` for select 0 and `tmr_b_rst` for select 1.
- R8: In mode 4'b1011, a match also raises `adc_start`, but only when `adc_enable` is high at that edge. No other mode raises `adc_start`.
- R9: `tmr_a_rst`, `tmr_b_rst` and `adc_start` are registered and stay high for exactly one clock.
- R10: A control write of 4'b0000 forces `pin_o` to 0 at the write edge. While the mode is 4'b0000, `pin_o` stays 0 and matches set no flag.
- R11: `pin_oe` equals `pin_dir` delayed by one clock. `pin_o` always carries the compare latch.
- R12: In any mode code not listed in R3, R6, R7 or R10, a match leaves `pin_o` unchanged, sets no flag and raises no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_wr | input | 1 | Write strobe for the compare value |
| cmp_wdata | input | TW | New compare value |
| ctl_wr | input | 1 | Write strobe for the mode code |
| ctl_wdata | input | 4 | New mode code |
| tsel_wr | input | 1 | Write strobe for the timer select |
| tsel_wdata | input | 1 | New timer select (0 = timer_a, 1 = timer_b) |
| timer_a | input | TW | Count of the first timer |
| timer_b | input | TW | Count of the second timer |
| adc_enable | input | 1 | Converter is enabled and may be started |
| pin_dir | input | 1 | 1 configures the pin as an output |
| flag_clr | input | 1 | Clear strobe for the interrupt flag |
| pin_o | output | 1 | Compare latch value driven toward the pin |
| pin_oe | output | 1 | Tristate output enable for the pin |
| irq_flag | output | 1 | Sticky match interrupt flag |
| tmr_a_rst | output | 1 | One-cycle reset pulse for timer_a |
| tmr_b_rst | output | 1 | One-cycle reset pulse for timer_b |
| adc_start | output | 1 | One-cycle conversion start pulse |

## Verification
The checker watches several properties on every clock. The pulses must last one cycle, and at most one timer reset may be high at a time. A conversion start must always come with a timer reset. The flag must stay set until it is cleared, and the pin must stay low after a zero control write or while the mode is off. In the software-interrupt mode the pin must hold still, and the output enable must follow the direction input.

Only the bench scenarios can show the rest. These cover the choice between the two timers, the single action for a long run of equality, the set, clear and toggle results, and the flag surviving a clear on the same edge as a match. A sweep over all sixteen mode codes, run with each select value and with the converter enabled and disabled, checks the pin, the flag and the pulses against values worked out from the requirements.

// File: rtl/cou_pkg.sv
`timescale 1ns/1ps
package cou_pkg;
  localparam int MODE_W = 4;

  localparam logic [MODE_W-1:0] MODE_OFF = 4'b0000;
  localparam logic [MODE_W-1:0] MODE_TOG = 4'b0010;
  localparam logic [MODE_W-1:0] MODE_SET = 4'b1000;
  localparam logic [MODE_W-1:0] MODE_CLR = 4'b1001;
  localparam logic [MODE_W-1:0] MODE_SWI = 4'b1010;
  localparam logic [MODE_W-1:0] MODE_SEV = 4'b1011;

  typedef struct packed {
    logic force_lo;
    logic drive_hi;
    logic drive_lo;
    logic invert;
    logic raise_flag;
    logic event_trig;
  } cmp_action_t;

  function automatic cmp_action_t decode_mode(input logic [MODE_W-1:0] m);
    cmp_action_t a;
    a.force_lo   = (m == MODE_OFF);
    a.drive_hi   = (m == MODE_SET);
    a.drive_lo   = (m == MODE_CLR);
    a.invert     = (m == MODE_TOG);
    a.event_trig = (m == MODE_SEV);
    a.raise_flag = (m == MODE_SET) || (m == MODE_CLR) || (m == MODE_TOG) ||
                   (m == MODE_SWI) || (m == MODE_SEV);
    return a;
  endfunction
endpackage

// File: rtl/cou_regs.sv
`timescale 1ns/1ps
module cou_regs #(
  parameter int TW = 16,
  parameter int SW = 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cmp_wr,
  input  logic [TW-1:0]              cmp_wdata,
  input  logic                       ctl_wr,
  input  logic [cou_pkg::MODE_W-1:0] ctl_wdata,
  input  logic                       tsel_wr,
  input  logic [SW-1:0]              tsel_wdata,
  input  logic                       pin_dir,
  output logic [TW-1:0]              cmp_q,
  output logic [cou_pkg::MODE_W-1:0] mode_q,
  output logic [SW-1:0]              tsel_q,
  output logic                       oe_q,
  output logic                       zero_wr
);
  assign zero_wr = ctl_wr && (ctl_wdata == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q  <= '0;
      mode_q <= '0;
      tsel_q <= '0;
      oe_q   <= 1'b0;
    end else begin
      if (cmp_wr)  cmp_q  <= cmp_wdata;
      if (ctl_wr)  mode_q <= ctl_wdata;
      if (tsel_wr) tsel_q <= tsel_wdata;
      oe_q <= pin_dir;
    end
  end
endmodule

// File: rtl/cou_match.sv
`timescale 1ns/1ps
module cou_match #(
  parameter int TW = 16,
  parameter int NT = 2,
  parameter int SW = 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NT-1:0][TW-1:0] timers,
  input  logic [TW-1:0]         cmp_q,
  input  logic [SW-1:0]         tsel_q,
  output logic                  hit
);
  logic [NT-1:0] eq_vec;
  logic          eq_sel;
  logic          eq_q;

  for (genvar i = 0; i < NT; i++) begin : g_cmp
    assign eq_vec[i] = (timers[i] == cmp_q);
  end

  assign eq_sel = eq_vec[tsel_q];
  assign hit    = eq_sel && !eq_q;

  always_ff @(posedge clk) begin
    if (rst) eq_q <= 1'b0;
    else     eq_q <= eq_sel;
  end
endmodule

// File: rtl/cou_action.sv
`timescale 1ns/1ps
module cou_action #(
  parameter int NT = 2,
  parameter int SW = 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 hit,
  input  cou_pkg::cmp_action_t act,
  input  logic                 zero_wr,
  input  logic [SW-1:0]        tsel_q,
  input  logic                 adc_enable,
  input  logic                 flag_clr,
  output logic                 pin_q,
  output logic                 flag_q,
  output logic [NT-1:0]        trst_q,
  output logic                 adc_q
);
  logic fire_trig;
  assign fire_trig = hit && act.event_trig;

  always_ff @(posedge clk) begin
    if (rst)                          pin_q <= 1'b0;
    else if (zero_wr || act.force_lo) pin_q <= 1'b0;
    else if (hit) begin
      if (act.drive_hi)      pin_q <= 1'b1;
      else if (act.drive_lo) pin_q <= 1'b0;
      else if (act.invert)   pin_q <= !pin_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                         flag_q <= 1'b0;
    else if (hit && act.raise_flag)  flag_q <= 1'b1;
    else if (flag_clr)               flag_q <= 1'b0;
  end

  for (genvar i = 0; i < NT; i++) begin : g_trst
    always_ff @(posedge clk) begin
      if (rst) trst_q[i] <= 1'b0;
      else     trst_q[i] <= fire_trig && (tsel_q == SW'(i));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) adc_q <= 1'b0;
    else     adc_q <= fire_trig && adc_enable;
  end
endmodule

// File: rtl/cmp_out_unit.sv
`timescale 1ns/1ps
module cmp_out_unit #(
  parameter int TW = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cmp_wr,
  input  logic [TW-1:0]              cmp_wdata,
  input  logic                       ctl_wr,
  input  logic [cou_pkg::MODE_W-1:0] ctl_wdata,
  input  logic                       tsel_wr,
  input  logic                       tsel_wdata,
  input  logic [TW-1:0]              timer_a,
  input  logic [TW-1:0]              timer_b,
  input  logic                       adc_enable,
  input  logic                       pin_dir,
  input  logic                       flag_clr,
  output logic                       pin_o,
  output logic                       pin_oe,
  output logic                       irq_flag,
  output logic                       tmr_a_rst,
  output logic                       tmr_b_rst,
  output logic                       adc_start
);
  localparam int NT = 2;
  localparam int SW = $clog2(NT);

  logic [TW-1:0]              cmp_q;
  logic [cou_pkg::MODE_W-1:0] mode_q;
  logic [SW-1:0]              tsel_q;
  logic                       zero_wr;
  logic                       hit;
  logic [NT-1:0][TW-1:0]      timers;
  logic [NT-1:0]              trst_q;
  cou_pkg::cmp_action_t       act;

  assign timers[0] = timer_a;
  assign timers[1] = timer_b;
  assign act       = cou_pkg::decode_mode(mode_q);

  cou_regs #(.TW(TW), .SW(SW)) regs_i (
    .clk(clk), .rst(rst),
    .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .tsel_wr(tsel_wr), .tsel_wdata(tsel_wdata),
    .pin_dir(pin_dir),
    .cmp_q(cmp_q), .mode_q(mode_q), .tsel_q(tsel_q),
    .oe_q(pin_oe), .zero_wr(zero_wr)
  );

  cou_match #(.TW(TW), .NT(NT), .SW(SW)) match_i (
    .clk(clk), .rst(rst),
    .timers(timers), .cmp_q(cmp_q), .tsel_q(tsel_q),
    .hit(hit)
  );

  cou_action #(.NT(NT), .SW(SW)) action_i (
    .clk(clk), .rst(rst),
    .hit(hit), .act(act), .zero_wr(zero_wr),
    .tsel_q(tsel_q), .adc_enable(adc_enable), .flag_clr(flag_clr),
    .pin_q(pin_o), .flag_q(irq_flag), .trst_q(trst_q), .adc_q(adc_start)
  );

  assign tmr_a_rst = trst_q[0];
  assign tmr_b_rst = trst_q[1];
endmodule

// File: rtl/cou_checker.sv
`timescale 1ns/1ps
module cou_checker (
  input logic       clk,
  input logic       rst,
  input logic       ctl_wr,
  input logic [3:0] ctl_wdata,
  input logic [3:0] mode_q,
  input logic       pin_dir,
  input logic       flag_clr,
  input logic       pin_o,
  input logic       pin_oe,
  input logic       irq_flag,
  input logic       tmr_a_rst,
  input logic       tmr_b_rst,
  input logic       adc_start
);
  assert_pulse_a_R9: assert property (@(posedge clk) disable iff (rst)
    tmr_a_rst |=> !tmr_a_rst);
  assert_pulse_b_R9: assert property (@(posedge clk) disable iff (rst)
    tmr_b_rst |=> !tmr_b_rst);
  assert_pulse_adc_R9: assert property (@(posedge clk) disable iff (rst)
    adc_start |=> !adc_start);
  assert_one_timer_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({tmr_a_rst, tmr_b_rst}));
  assert_adc_with_trig_R8: assert property (@(posedge clk) disable iff (rst)
    adc_start |-> (tmr_a_rst || tmr_b_rst));
  assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    (irq_flag && !flag_clr) |=> irq_flag);
  assert_zero_write_R10: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && ctl_wdata == 4'b0000) |=> !pin_o);
  assert_off_low_R10: assert property (@(posedge clk) disable iff (rst)
    (mode_q == 4'b0000) |=> !pin_o);
  assert_swi_pin_R6: assert property (@(posedge clk) disable iff (rst)
    (mode_q == 4'b1010 && !ctl_wr) |=> $stable(pin_o));
  assert_sev_pin_R7: assert property (@(posedge clk) disable iff (rst)
    (mode_q == 4'b1011 && !ctl_wr) |=> $stable(pin_o));
  assert_oe_on_R11: assert property (@(posedge clk) disable iff (rst)
    pin_dir |=> pin_oe);
  assert_oe_off_R11: assert property (@(posedge clk) disable iff (rst)
    !pin_dir |=> !pin_oe);
endmodule

bind cmp_out_unit cou_checker chk_i (
  .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
  .mode_q(mode_q), .pin_dir(pin_dir), .flag_clr(flag_clr),
  .pin_o(pin_o), .pin_oe(pin_oe), .irq_flag(irq_flag),
  .tmr_a_rst(tmr_a_rst), .tmr_b_rst(tmr_b_rst), .adc_start(adc_start)
);

// File: tb/cmp_out_unit_tb_top.sv
`timescale 1ns/1ps
module cmp_out_unit_tb_top;
  localparam int TW = 16;
  localparam logic [TW-1:0] CV = 16'd100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmp_wr = 0, ctl_wr = 0, tsel_wr = 0, tsel_wdata = 0;
  logic [TW-1:0] cmp_wdata = '0, timer_a = '0, timer_b = '0;
  logic [3:0] ctl_wdata = '0;
  logic adc_enable = 0, pin_dir = 0, flag_clr = 0;
  logic pin_o, pin_oe, irq_flag, tmr_a_rst, tmr_b_rst, adc_start;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  cmp_out_unit #(.TW(TW)) dut_i (
    .clk(clk), .rst(rst),
    .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .tsel_wr(tsel_wr), .tsel_wdata(tsel_wdata),
    .timer_a(timer_a), .timer_b(timer_b),
    .adc_enable(adc_enable), .pin_dir(pin_dir), .flag_clr(flag_clr),
    .pin_o(pin_o), .pin_oe(pin_oe), .irq_flag(irq_flag),
    .tmr_a_rst(tmr_a_rst), .tmr_b_rst(tmr_b_rst), .adc_start(adc_start)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic set_both(input logic [TW-1:0] v);
    timer_a = v;
    timer_b = v;
  endtask

  task automatic write_mode(input logic [3:0] m);
    ctl_wr = 1; ctl_wdata = m;
    step();
    ctl_wr = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    logic exp_pin;
    repeat (3) step();
    rst = 0;
    // R1 reset state
    chk("R1 outputs", {26'd0, pin_o, pin_oe, irq_flag, tmr_a_rst, tmr_b_rst, adc_start}, 32'd0);
    step();
    chk("R1 after release", {26'd0, pin_o, pin_oe, irq_flag, tmr_a_rst, tmr_b_rst, adc_start}, 32'd0);

    pin_dir = 1;
    step();
    chk("R11 oe on", pin_oe, 1);

    cmp_wr = 1; cmp_wdata = CV; timer_a = 16'd50; timer_b = 16'd60;
    step();
    cmp_wr = 0;
    write_mode(4'b1000);
    timer_b = CV;
    step();
    chk("R2 unselected timer pin", pin_o, 0);
    chk("R2 unselected timer flag", irq_flag, 0);
    timer_a = CV;
    step();
    chk("R3 set mode", pin_o, 1);
    chk("R5 flag set", irq_flag, 1);
    flag_clr = 1;
    step();
    flag_clr = 0;
    chk("R5 flag cleared", irq_flag, 0);
    step();
    chk("R4 no repeat while equal", irq_flag, 0);

    // select timer_b, clear mode
    timer_a = 16'd0;
    write_mode(4'b1001);
    tsel_wr = 1; tsel_wdata = 1;
    step();
    tsel_wr = 0;
    step();
    chk("R2 timer_b selected", irq_flag, 1);
    chk("R3 clear mode", pin_o, 0);

    // toggle mode
    flag_clr = 1; timer_b = 16'd0;
    write_mode(4'b0010);
    flag_clr = 0;
    exp_pin = 0;
    for (int k = 0; k < 4; k++) begin
      timer_b = CV;
      step();
      exp_pin = !exp_pin;
      chk("R3 toggle", pin_o, exp_pin);
      step();
      step();
      chk("R4 toggle held", pin_o, exp_pin);
      timer_b = 16'd0;
      step();
    end

    // clear and match on the same edge
    flag_clr = 1; timer_b = CV;
    step();
    flag_clr = 0;
    chk("R5 set wins over clear", irq_flag, 1);
    timer_b = 16'd0;
    step();

    // sweep of all mode codes, for each select and converter enable
    for (int p = 0; p < 2; p++) begin
      tsel_wr = 1; tsel_wdata = p[0]; adc_enable = p[0];
      set_both(CV + 16'd1);
      step();
      tsel_wr = 0;
      for (int m = 0; m < 16; m++) begin
        logic fl, tr;
        write_mode(4'b1000);
        set_both(CV);
        step();
        chk("R3 preset high", pin_o, 1);
        set_both(CV + 16'd1); flag_clr = 1;
        step();
        flag_clr = 0;
        write_mode(m[3:0]);
        chk("R10 R12 after mode write", pin_o, (m == 0) ? 1'b0 : 1'b1);
        set_both(CV);
        step();
        fl = (m == 2) || (m == 8) || (m == 9) || (m == 10) || (m == 11);
        tr = (m == 11);
        chk("R6 R7 R10 R12 sweep pin", pin_o,
            ((m == 0) || (m == 2) || (m == 9)) ? 1'b0 : 1'b1);
        chk("R5 R12 sweep flag", irq_flag, fl);
        chk("R7 sweep timer_a reset", tmr_a_rst, tr && (p == 0));
        chk("R7 sweep timer_b reset", tmr_b_rst, tr && (p == 1));
        chk("R8 sweep adc start", adc_start, tr && (p == 1));
        step();
        chk("R9 pulses end", {tmr_a_rst, tmr_b_rst, adc_start}, 3'b000);
        chk("R4 flag held", irq_flag, fl);
        set_both(CV + 16'd1);
        step();
      end
    end

    pin_dir = 0;
    step();
    chk("R11 oe off", pin_oe, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule